// File: doc/BRIEF.md
# Two-Stage Precomputed-Parameter Associative Memory

This block is a small associative (content-addressable) memory of `WORDS` entries, each `WIDTH` bits wide, that avoids most full-width comparisons. When a word is written, a short signature of it is computed and kept beside it. A search first compares the signature of the key with every stored signature. It then compares the full key only against the words whose signature agreed.

By default the signature is the population count of the word. A build-time parameter can select a block-XOR signature instead, which spreads the values more evenly. The same signature function serves writes and searches. A search takes two clock cycles, one per stage. The result gives a match flag, the lowest matching index, a per-word hit vector, and the number of words admitted to the full comparison. That number serves as a power proxy.

Top module: `precomp_cam`

## Requirements
- R1: A write with `wr_en`=1 stores `wr_data` at `wr_addr` along with the valid bit `wr_valid`. A later search whose key equals that word sets `rslt_match`=1 and sets bit `wr_addr` of `rslt_hits`.
- R2: In the default mode (`PARAM_MODE`=0) the signature is the number of ones in the word. It is `ceil(log2(WIDTH+2))` bits wide. `rslt_cmp_cnt` equals the number of valid words whose signature equals the key's signature.
- R3: A word whose signature differs from the key's never sets its hit bit. `rslt_match` equals the OR of `rslt_hits`, and the number of set hit bits never exceeds `rslt_cmp_cnt`.
- R4: A word written with `wr_valid`=0 is excluded from both stages. It neither hits nor adds to `rslt_cmp_cnt`, even when its data equals the key.
- R5: When several words hit, `rslt_addr` is the lowest hitting index and every hitting word has its bit set in `rslt_hits`.
- R6: `rslt_valid` is high in exactly the cycle two clocks after a cycle with `srch_en`=1 and low otherwise. Searches on consecutive cycles give results on consecutive cycles.
- R7: A write issued in the same cycle as a search is not seen by that search, which uses the old contents. A write issued in any earlier cycle is seen.
- R8: While `rst_n` is low at a clock edge, all valid bits and `rslt_valid` are cleared. After reset every search reports no match and a count of zero.
- R9: With `PARAM_MODE`=1 the word is zero-padded to `P*B` bits, where `P` is the signature width and `B=ceil(WIDTH/P)`. Signature bit `b` is the XOR of padded bits `b*B` through `b*B+B-1`. `rslt_cmp_cnt` counts valid words with an equal signature of this kind.
- R10: A search that hits nothing returns `rslt_match`=0 and `rslt_hits`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word index to write |
| wr_data | input | WIDTH | Data to store |
| wr_valid | input | 1 | Valid bit stored with the word |
| srch_en | input | 1 | Start a search with `srch_key` |
| srch_key | input | WIDTH | Search key |
| rslt_valid | output | 1 | Result of the search issued two cycles earlier |
| rslt_match | output | 1 | At least one word hit |
| rslt_addr | output | AW | Lowest hitting word index |
| rslt_hits | output | WORDS | Per-word hit vector |
| rslt_cmp_cnt | output | CW | Words admitted to the full comparison |

## Verification
A write and a search can land in the same cycle, and they can target the same word. The bench provokes this by writing a new value into a word in the very cycle a search for that word's old value starts. It expects the search to find the old value at that index. A follow-up search must then find the new value, and a repeat search for the old value must miss. Both signature modes run side by side on identical stimulus, and each mode's count is judged against its own reference signature.

// File: rtl/pcam_pkg.sv
// Shared constants and helpers for the precomputed-parameter CAM.
package pcam_pkg;
    localparam int PMODE_ONES = 0;  // signature = population count
    localparam int PMODE_BXOR = 1;  // signature = per-block XOR

    // Signature width needed to hold a count of 0..w, with one spare code.
    function automatic int par_bits(input int w);
        return $clog2(w + 2);
    endfunction
endpackage

// File: rtl/pcam_param_gen.sv
// Signature extractor: computes the short parameter of a data word.
// Assumes PAR_W >= number of bits needed for WIDTH (ones mode).
module pcam_param_gen #(
    parameter int WIDTH = 14,
    parameter int PAR_W = 4,
    parameter int MODE  = 0
) (
    input  logic [WIDTH-1:0] din,
    output logic [PAR_W-1:0] par
);
    generate
        if (MODE == pcam_pkg::PMODE_BXOR) begin : g_bxor
            localparam int BLK  = (WIDTH + PAR_W - 1) / PAR_W;
            localparam int PADW = BLK * PAR_W;
            logic [PADW-1:0] padded;
            assign padded = PADW'(din);
            for (genvar b = 0; b < PAR_W; b++) begin : g_blk
                // reduce one block to a single signature bit
                assign par[b] = ^padded[b*BLK +: BLK];
            end
        end else begin : g_ones
            // add up the set bits of the word
            always_comb begin
                par = '0;
                for (int i = 0; i < WIDTH; i++) par = par + PAR_W'(din[i]);
            end
        end
    endgenerate
endmodule

// File: rtl/pcam_store.sv
// Word, signature and valid-bit storage with a single write port.
// Assumes wr_addr < WORDS; data and signature need no reset.
module pcam_store #(
    parameter int WORDS = 8,
    parameter int WIDTH = 14,
    parameter int PAR_W = 4,
    parameter int AW    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic [PAR_W-1:0]             wr_par,
    input  logic                         wr_valid,
    output logic [WORDS-1:0][WIDTH-1:0]  mem_data,
    output logic [WORDS-1:0][PAR_W-1:0]  mem_par,
    output logic [WORDS-1:0]             mem_vld
);
    // valid bits: cleared by reset, set or cleared by writes
    always_ff @(posedge clk) begin
        if (!rst_n)     mem_vld <= '0;
        else if (wr_en) mem_vld[wr_addr] <= wr_valid;
    end

    // data and signature payload
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_data[wr_addr] <= wr_data;
            mem_par[wr_addr]  <= wr_par;
        end
    end
endmodule

// File: rtl/pcam_stage2.sv
// Second search stage: full compare on admitted words only, priority
// encode the lowest hit, and count admitted words. Purely combinational.
// A bypass supplies the pre-write compare for a word overwritten in the
// cycle the search was issued.
module pcam_stage2 #(
    parameter int WORDS = 8,
    parameter int WIDTH = 14,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic [WIDTH-1:0]             key,
    input  logic [WORDS-1:0]             cand,
    input  logic [WORDS-1:0][WIDTH-1:0] mem_data,
    input  logic                         byp_en,
    input  logic [AW-1:0]                byp_idx,
    input  logic                         byp_hit,
    output logic [WORDS-1:0]             hits,
    output logic                         found,
    output logic [AW-1:0]                first,
    output logic [CW-1:0]                cnt
);
    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_cmp
            logic use_byp;
            assign use_byp = byp_en && (byp_idx == AW'(i));
            // compare only when stage one admitted the word
            assign hits[i] = cand[i] && (use_byp ? byp_hit : (mem_data[i] == key));
        end
    endgenerate

    // lowest-index hit wins
    always_comb begin
        found = 1'b0;
        first = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                first = AW'(i);
            end
        end
    end

    // number of words that entered the full compare
    always_comb begin
        cnt = '0;
        for (int i = 0; i < WORDS; i++) cnt = cnt + CW'(cand[i]);
    end
endmodule

// File: rtl/precomp_cam.sv
// Precomputed-parameter CAM top. Cycle s: signature compare against all
// words, key and candidate mask registered. Cycle s+1: full compare on
// candidates, result registered, visible in cycle s+2.
// Assumes wr_addr < WORDS.
module precomp_cam #(
    parameter int WORDS      = 8,
    parameter int WIDTH      = 14,
    parameter int PARAM_MODE = 0,
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int CW    = $clog2(WORDS + 1),
    localparam int PAR_W = pcam_pkg::par_bits(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_key,
    output logic             rslt_valid,
    output logic             rslt_match,
    output logic [AW-1:0]    rslt_addr,
    output logic [WORDS-1:0] rslt_hits,
    output logic [CW-1:0]    rslt_cmp_cnt
);
    logic [PAR_W-1:0]             wr_par, key_par;
    logic [WORDS-1:0][WIDTH-1:0]  mem_data;
    logic [WORDS-1:0][PAR_W-1:0]  mem_par;
    logic [WORDS-1:0]             mem_vld;
    logic [WORDS-1:0]             cand;
    logic                         byp_hit;

    logic                         s1_vld;
    logic [WIDTH-1:0]             s1_key;
    logic [WORDS-1:0]             s1_cand;
    logic                         s1_byp_en;
    logic [AW-1:0]                s1_byp_idx;
    logic                         s1_byp_hit;

    logic [WORDS-1:0]             s2_hits;
    logic                         s2_found;
    logic [AW-1:0]                s2_first;
    logic [CW-1:0]                s2_cnt;

    pcam_param_gen #(.WIDTH(WIDTH), .PAR_W(PAR_W), .MODE(PARAM_MODE)) u_wpar (
        .din(wr_data), .par(wr_par));

    pcam_param_gen #(.WIDTH(WIDTH), .PAR_W(PAR_W), .MODE(PARAM_MODE)) u_kpar (
        .din(srch_key), .par(key_par));

    pcam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .PAR_W(PAR_W), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_par(wr_par), .wr_valid(wr_valid),
        .mem_data(mem_data), .mem_par(mem_par), .mem_vld(mem_vld));

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_s1
            // stage one: signature compare, gated by the valid bit
            assign cand[i] = mem_vld[i] && (mem_par[i] == key_par);
        end
    endgenerate

    // pre-write full compare for a word being overwritten this cycle
    assign byp_hit = (mem_data[wr_addr] == srch_key);

    // stage-one valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) s1_vld <= 1'b0;
        else        s1_vld <= srch_en;
    end

    // stage-one payload: key, candidate mask, collision bypass
    always_ff @(posedge clk) begin
        if (srch_en) begin
            s1_key     <= srch_key;
            s1_cand    <= cand;
            s1_byp_en  <= wr_en;
            s1_byp_idx <= wr_addr;
            s1_byp_hit <= byp_hit;
        end
    end

    pcam_stage2 #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .CW(CW)) u_stage2 (
        .key(s1_key), .cand(s1_cand), .mem_data(mem_data),
        .byp_en(s1_byp_en), .byp_idx(s1_byp_idx), .byp_hit(s1_byp_hit),
        .hits(s2_hits), .found(s2_found), .first(s2_first), .cnt(s2_cnt));

    // result registers, updated only when a search completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rslt_valid   <= 1'b0;
            rslt_match   <= 1'b0;
            rslt_addr    <= '0;
            rslt_hits    <= '0;
            rslt_cmp_cnt <= '0;
        end else begin
            rslt_valid <= s1_vld;
            if (s1_vld) begin
                rslt_match   <= s2_found;
                rslt_addr    <= s2_first;
                rslt_hits    <= s2_hits;
                rslt_cmp_cnt <= s2_cnt;
            end
        end
    end
endmodule

// File: rtl/pcam_chk.sv
// Protocol and result-consistency checks for precomp_cam, bound below.
module pcam_chk #(
    parameter int WORDS = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_en,
    input logic             rslt_valid,
    input logic             rslt_match,
    input logic [AW-1:0]    rslt_addr,
    input logic [WORDS-1:0] rslt_hits,
    input logic [CW-1:0]    rslt_cmp_cnt
);
    a_r6_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |-> ##2 rslt_valid);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |-> $past(srch_en, 2));

    a_r3_match_is_or: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |-> (rslt_match == (|rslt_hits)));

    a_r3_hits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |-> ($countones(rslt_hits) <= int'(rslt_cmp_cnt)));

    a_r5_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
        (rslt_valid && rslt_match) |->
            (rslt_hits[rslt_addr] &&
             ((rslt_hits & ((WORDS'(1) << rslt_addr) - WORDS'(1))) == '0)));

    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !rslt_valid);
endmodule

bind precomp_cam pcam_chk #(.WORDS(WORDS), .AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .rslt_valid(rslt_valid),
    .rslt_match(rslt_match), .rslt_addr(rslt_addr), .rslt_hits(rslt_hits),
    .rslt_cmp_cnt(rslt_cmp_cnt));

// File: tb/precomp_cam_tb.sv
`timescale 1ns/1ps
module precomp_cam_tb;
    localparam int WORDS = 8;
    localparam int WIDTH = 14;
    localparam int AW = 3;
    localparam int CW = 4;

    typedef struct packed {
        logic             is_srch;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
        logic             vld;
        logic             exp_match;
        logic [AW-1:0]    exp_addr;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 14'h0003, 1'b1, 1'b0, 3'd0},
        '{1'b0, 3'd1, 14'h0005, 1'b1, 1'b0, 3'd0},
        '{1'b0, 3'd2, 14'h00F0, 1'b1, 1'b0, 3'd0},
        '{1'b0, 3'd3, 14'h0005, 1'b1, 1'b0, 3'd0},
        '{1'b0, 3'd4, 14'h3FFF, 1'b1, 1'b0, 3'd0},
        '{1'b0, 3'd5, 14'h0000, 1'b1, 1'b0, 3'd0},
        '{1'b0, 3'd6, 14'h0006, 1'b0, 1'b0, 3'd0},
        '{1'b0, 3'd7, 14'h1234, 1'b1, 1'b0, 3'd0},
        '{1'b1, 3'd0, 14'h0005, 1'b0, 1'b1, 3'd1},
        '{1'b1, 3'd0, 14'h0003, 1'b0, 1'b1, 3'd0},
        '{1'b1, 3'd0, 14'h0006, 1'b0, 1'b0, 3'd0},
        '{1'b1, 3'd0, 14'h0009, 1'b0, 1'b0, 3'd0},
        '{1'b1, 3'd0, 14'h3FFF, 1'b0, 1'b1, 3'd4},
        '{1'b1, 3'd0, 14'h0000, 1'b0, 1'b1, 3'd5},
        '{1'b1, 3'd0, 14'h00F0, 1'b0, 1'b1, 3'd2},
        '{1'b1, 3'd0, 14'h1234, 1'b0, 1'b1, 3'd7},
        '{1'b1, 3'd0, 14'h0001, 1'b0, 1'b0, 3'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_valid = 1'b0, srch_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0, srch_key = '0;
    logic rv_a, rm_a, rv_b, rm_b;
    logic [AW-1:0] ra_a, ra_b;
    logic [WORDS-1:0] rh_a, rh_b;
    logic [CW-1:0] rc_a, rc_b;

    always #2 clk = ~clk;

    precomp_cam #(.WORDS(WORDS), .WIDTH(WIDTH), .PARAM_MODE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_valid(wr_valid), .srch_en(srch_en),
        .srch_key(srch_key), .rslt_valid(rv_a), .rslt_match(rm_a),
        .rslt_addr(ra_a), .rslt_hits(rh_a), .rslt_cmp_cnt(rc_a));

    precomp_cam #(.WORDS(WORDS), .WIDTH(WIDTH), .PARAM_MODE(1)) u_dut_bx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_valid(wr_valid), .srch_en(srch_en),
        .srch_key(srch_key), .rslt_valid(rv_b), .rslt_match(rm_b),
        .rslt_addr(ra_b), .rslt_hits(rh_b), .rslt_cmp_cnt(rc_b));

    int n_chk = 0, n_fail = 0;
    logic [WIDTH-1:0] m_data [WORDS];
    logic m_vld [WORDS];

    typedef struct {
        logic match;
        logic [AW-1:0] addr;
        logic [WORDS-1:0] hits;
        int cnt_ones;
        int cnt_bx;
    } exp_t;

    function automatic int popc(input logic [WIDTH-1:0] d);
        int s = 0;
        for (int i = 0; i < WIDTH; i++) s += int'(d[i]);
        return s;
    endfunction

    function automatic logic [3:0] bxsig(input logic [WIDTH-1:0] d);
        logic [15:0] p = {2'b00, d};
        logic [3:0] r;
        for (int b = 0; b < 4; b++) r[b] = ^p[b*4 +: 4];
        return r;
    endfunction

    function automatic exp_t model(input logic [WIDTH-1:0] key);
        exp_t e;
        e.match = 1'b0; e.addr = '0; e.hits = '0; e.cnt_ones = 0; e.cnt_bx = 0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (m_vld[i]) begin
                if (popc(m_data[i]) == popc(key)) e.cnt_ones++;
                if (bxsig(m_data[i]) == bxsig(key)) e.cnt_bx++;
                if (m_data[i] == key) begin
                    e.hits[i] = 1'b1; e.match = 1'b1; e.addr = AW'(i);
                end
            end
        end
        return e;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_both(input string req, input exp_t e);
        chk("R6", "valid ones", 32'(rv_a), 32'd1);
        chk("R6", "valid bxor", 32'(rv_b), 32'd1);
        chk(req, "match ones", 32'(rm_a), 32'(e.match));
        chk(req, "match bxor", 32'(rm_b), 32'(e.match));
        chk(req, "hits ones", 32'(rh_a), 32'(e.hits));
        chk(req, "hits bxor", 32'(rh_b), 32'(e.hits));
        if (e.match) begin
            chk("R5", "addr ones", 32'(ra_a), 32'(e.addr));
            chk("R5", "addr bxor", 32'(ra_b), 32'(e.addr));
        end
        chk("R2", "count ones", 32'(rc_a), 32'(e.cnt_ones));
        chk("R9", "count bxor", 32'(rc_b), 32'(e.cnt_bx));
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [WIDTH-1:0] d,
                            input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_data[a] = d; m_vld[a] = v;
    endtask

    task automatic do_search(input string req, input logic [WIDTH-1:0] key,
                             output exp_t e);
        @(negedge clk);
        srch_en = 1'b1; srch_key = key;
        e = model(key);
        @(negedge clk);
        srch_en = 1'b0;
        chk("R6", "early valid", 32'(rv_a | rv_b), 32'd0);
        @(negedge clk);
        check_both(req, e);
    endtask

    task automatic run_all();
        exp_t e, e2;
        for (int i = 0; i < WORDS; i++) begin m_vld[i] = 1'b0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R8", "valid in reset", 32'(rv_a | rv_b), 32'd0);
        rst_n = 1'b1;
        // R8: empty array after reset
        do_search("R8", 14'h0000, e);

        // table walk: writes fill the array, searches cover R1 R2 R3 R4 R5 R10
        for (int v = 0; v < NV; v++) begin
            if (!VEC[v].is_srch) begin
                do_write(VEC[v].addr, VEC[v].data, VEC[v].vld);
            end else begin
                do_search("R1", VEC[v].data, e);
                chk("R1", "table match", 32'(rm_a), 32'(VEC[v].exp_match));
                if (VEC[v].exp_match) chk("R5", "table addr", 32'(ra_a), 32'(VEC[v].exp_addr));
                else chk("R10", "empty hits", 32'(rh_a), 32'd0);
            end
        end
        // R4: invalid word with identical data is never reported
        chk("R4", "invalid word hit", 32'(rh_a[6]), 32'd0);

        // R7: write and search on the same word in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 14'h0011; wr_valid = 1'b1;
        srch_en = 1'b1; srch_key = 14'h0000;
        e = model(14'h0000);
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        m_data[5] = 14'h0011;
        @(negedge clk);
        check_both("R7", e);
        chk("R7", "old value found", 32'(ra_a), 32'd5);
        do_search("R7", 14'h0011, e);
        chk("R7", "new value found", 32'(rm_a), 32'd1);
        do_search("R7", 14'h0000, e);
        chk("R7", "old value gone", 32'(rm_a), 32'd0);

        // R6: back-to-back searches
        @(negedge clk);
        srch_en = 1'b1; srch_key = 14'h0005; e = model(14'h0005);
        @(negedge clk);
        srch_key = 14'h3FFF; e2 = model(14'h3FFF);
        @(negedge clk);
        srch_en = 1'b0;
        check_both("R6", e);
        @(negedge clk);
        check_both("R6", e2);
        @(negedge clk);
        chk("R6", "valid drops", 32'(rv_a | rv_b), 32'd0);

        // R8: mid-run reset clears every valid bit
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WORDS; i++) m_vld[i] = 1'b0;
        do_search("R8", 14'h3FFF, e);
        chk("R8", "count after reset", 32'(rc_a), 32'd0);
    endtask

    initial begin
        logic timeout = 1'b0;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule